// File: doc/BRIEF.md
# In-band XON/XOFF flow controller

This block runs flow control for one serial channel using flow-control characters carried in the data stream. It looks at every received character and at the fill level of the receive FIFO. It does four things:

- It can stop the local transmitter when the far end sends a stop character and let it run again on a resume character.
- It can ask the transmitter to insert a stop character when the local receive FIFO is nearly full, and a resume character once the FIFO has drained.
- It decides whether received flow-control characters go into the receive FIFO or are dropped.
- It keeps a status register that clears when read and drives an interrupt through per-character enables.

Serial framing, baud generation and the FIFO itself belong to neighbouring blocks.

There are two state machines. The transmit gate has three states:

- `G_RUN`: the transmitter may start characters.
- `G_DRAIN`: a stop character arrived while a character was still going out.
- `G_HALT`: stopped.

Its transitions are:

- `G_RUN`→`G_DRAIN` on a stop character while `tx_busy` is high.
- `G_RUN`→`G_HALT` on a stop character while `tx_busy` is low.
- `G_DRAIN`→`G_HALT` when `tx_busy` falls.
- `G_DRAIN`/`G_HALT`→`G_RUN` on a resume character, or whenever automatic transmit control is off.

The emitter holds the one "stop sent" flag and has five states:

- `E_CLEAR`: no stop sent.
- `E_REQ_XOFF`: stop requested.
- `E_HELD`: stop sent.
- `E_REQ_XON`: resume requested.
- `E_HOST_REQ`: a host-commanded character is requested.

Its transitions are:

- `E_CLEAR`→`E_REQ_XOFF` when the level is 240 or more.
- `E_REQ_XOFF`→`E_HELD` on acknowledge.
- `E_HELD`→`E_REQ_XON` when the level is 128 or less.
- `E_REQ_XON`→`E_CLEAR` on acknowledge.
- `E_CLEAR`→`E_HOST_REQ` on a host command in host mode.
- `E_HOST_REQ`→`E_CLEAR` on acknowledge.
- Any state →`E_CLEAR` on a mode change.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: After reset `tx_allow`=1, `ins_req`=0, `irq`=0, the control register (address 0) reads 0, the resume code (address 1) reads 0x11 and the stop code (address 2) reads 0x13.
- R2: Control bits [1:0] select the mode: 00 host only, 01 automatic transmit gating, 10 automatic receive-side emission, 11 both. When bit 0 is set, a received stop code drives `tx_allow` low from the next clock and a received resume code drives it high from the next clock. When bit 0 is clear, `tx_allow` returns high on the next clock.
- R3: A stop code received while `tx_busy`=1 drops `tx_allow` at the next clock. Status bit 3 (transmitter halted) rises only on the clock after `tx_busy` falls.
- R4: When control bit 1 is set and no stop has been sent, a FIFO level of 240 or more raises `ins_req` with `ins_char` equal to the stop code at the next clock. The request is held until `ins_ack`.
- R5: After the stop request is acknowledged, no further stop is requested. A resume request (`ins_char` = resume code) is raised at the clock after the level falls to 128 or less.
- R6: In mode 00, a `cmd_xoff` or `cmd_xon` pulse raises `ins_req` with the stop or resume code at the next clock, and `cmd_xoff` wins if both pulse together. In any other mode these commands are ignored.
- R7: Control bit 2 selects stripping. When it is 0, received flow-control characters drive `rx_wr_en` like data. When it is 1, they do not drive `rx_wr_en`. Other characters always drive `rx_wr_en` in the same cycle as `rx_valid`.
- R8: Status register (address 3) bits:
  - bit 0: a resume code was received.
  - bit 1: a stop code was received.
  - bit 2: the last flow-control code received was a stop code.
  - bit 3: the transmitter is halted.

  Bits 0 to 2 update on the clock after a match, in every mode. `irq` = (bit 0 AND control bit 3) OR (bit 1 AND control bit 4).
- R9: A read of address 3 clears status bits 0 to 2 at that clock edge (a match in the same cycle wins), so `irq` falls on the next clock.
- R10: The resume and stop codes are writable at addresses 1 and 2. A character matches only when all 8 bits are equal. If both codes match, the stop code wins.
- R11: Any change of the mode field clears the "stop sent" flag and cancels a pending insertion request within two clocks of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_wr_en | output | 1 | Write strobe to receive FIFO |
| rx_wr_data | output | 8 | Character written to receive FIFO |
| fifo_level | input | 9 | Receive FIFO fill level |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_allow | output | 1 | Transmitter may start a data character |
| ins_req | output | 1 | Request to insert a flow-control character |
| ins_char | output | 8 | Character to insert |
| ins_ack | input | 1 | Transmitter accepted the insertion |
| cmd_xon | input | 1 | Host command: send resume code |
| cmd_xoff | input | 1 | Host command: send stop code |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Flow-control interrupt |

## Verification
The FIFO write strobe is combinational, so the bench samples it in the same cycle as `rx_valid`. The status bits, `irq`, the transmit gate and new insertion requests appear one clock after their cause, and the bench samples them at the falling edge that follows that rising edge. A mode change takes one clock to reach the register and one more to reset the emitter, so the bench waits two clocks after such a write. Drain-to-halt and acknowledge-to-release are each checked one clock after the enabling input edge.

// File: rtl/xfc_pkg.sv
`timescale 1ns/1ps
package xfc_pkg;
    localparam logic [7:0] RESUME_CODE_RST = 8'h11;
    localparam logic [7:0] STOP_CODE_RST   = 8'h13;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_RESUME = 2'd1;
    localparam logic [1:0] ADR_STOP = 2'd2;
    localparam logic [1:0] ADR_STAT = 2'd3;

    localparam int CTRL_W = 5;

    typedef enum logic [1:0] {
        G_RUN,
        G_DRAIN,
        G_HALT
    } gate_state_e;

    typedef enum logic [2:0] {
        E_CLEAR,
        E_REQ_XOFF,
        E_HELD,
        E_REQ_XON,
        E_HOST_REQ
    } emit_state_e;
endpackage

// File: rtl/xfc_regs.sv
`timescale 1ns/1ps
module xfc_regs
    import xfc_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          resume_hit,
    input  logic          stop_hit,
    input  logic          tx_halted,
    output logic [1:0]    mode,
    output logic          strip,
    output logic [DW-1:0] resume_code,
    output logic [DW-1:0] stop_code,
    output logic          irq
);
    localparam int STAT_W = 3;

    logic [CTRL_W-1:0] ctrl_q;
    logic [DW-1:0]     resume_q;
    logic [DW-1:0]     stop_q;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] stat_base;
    logic              stat_read;

    assign stat_read = reg_rd && (reg_addr == ADR_STAT);

    always_comb begin
        stat_base = stat_read ? '0 : stat_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            resume_q <= RESUME_CODE_RST;
            stop_q   <= STOP_CODE_RST;
        end else if (reg_wr) begin
            unique case (reg_addr)
                ADR_CTRL:   ctrl_q   <= reg_wdata[CTRL_W-1:0];
                ADR_RESUME: resume_q <= reg_wdata;
                ADR_STOP:   stop_q   <= reg_wdata;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q[0] <= stat_base[0] | resume_hit;
            stat_q[1] <= stat_base[1] | stop_hit;
            stat_q[2] <= (resume_hit || stop_hit) ? stop_hit : stat_base[2];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADR_CTRL:   reg_rdata[CTRL_W-1:0] = ctrl_q;
            ADR_RESUME: reg_rdata = resume_q;
            ADR_STOP:   reg_rdata = stop_q;
            default:    reg_rdata[STAT_W:0] = {tx_halted, stat_q};
        endcase
    end

    assign mode        = ctrl_q[1:0];
    assign strip       = ctrl_q[2];
    assign resume_code = resume_q;
    assign stop_code   = stop_q;
    assign irq         = (stat_q[0] & ctrl_q[3]) | (stat_q[1] & ctrl_q[4]);

    // R8
    stop_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_hit |=> (stat_q[1] && stat_q[2]));

    // R8
    resume_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_hit |=> (stat_q[0] && !stat_q[2]));

    // R9
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_read && !resume_hit && !stop_hit) |=> !irq);

    // R10
    code_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADR_STOP) |=> (stop_code == $past(reg_wdata)));
endmodule

// File: rtl/xfc_tx_gate.sv
`timescale 1ns/1ps
module xfc_tx_gate
    import xfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_tx,
    input  logic resume_hit,
    input  logic stop_hit,
    input  logic tx_busy,
    output logic tx_allow,
    output logic tx_halted
);
    gate_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= G_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            G_RUN: begin
                if (stop_hit) state_d = tx_busy ? G_DRAIN : G_HALT;
            end
            G_DRAIN: begin
                if (resume_hit)    state_d = G_RUN;
                else if (!tx_busy) state_d = G_HALT;
            end
            G_HALT: begin
                if (resume_hit) state_d = G_RUN;
            end
            default: state_d = G_RUN;
        endcase
        if (!auto_tx) state_d = G_RUN;
    end

    always_comb begin
        tx_allow  = (state_q == G_RUN);
        tx_halted = (state_q == G_HALT);
    end

    // R2
    off_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_tx |=> tx_allow);

    // R2
    stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_tx && stop_hit) |=> !tx_allow);

    // R3
    drain_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_tx && tx_allow && stop_hit && tx_busy) |=> (!tx_halted && !tx_allow));
endmodule

// File: rtl/xfc_rx_emit.sv
`timescale 1ns/1ps
module xfc_rx_emit
    import xfc_pkg::*;
#(
    parameter int DW      = 8,
    parameter int LVL_W   = 9,
    parameter int HI_MARK = 240,
    parameter int LO_MARK = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [LVL_W-1:0] level,
    input  logic             cmd_xon,
    input  logic             cmd_xoff,
    input  logic             ins_ack,
    input  logic [DW-1:0]    resume_code,
    input  logic [DW-1:0]    stop_code,
    output logic             ins_req,
    output logic [DW-1:0]    ins_char
);
    localparam logic [LVL_W-1:0] HI_LVL = LVL_W'(HI_MARK);
    localparam logic [LVL_W-1:0] LO_LVL = LVL_W'(LO_MARK);

    emit_state_e state_q, state_d;
    logic [1:0]  mode_q;
    logic        mode_chg;
    logic        auto_rx;
    logic        host_mode;
    logic        host_take;
    logic        host_stop_q;
    logic        above_hi;
    logic        below_lo;

    assign mode_chg  = (mode != mode_q);
    assign auto_rx   = mode[1];
    assign host_mode = (mode == 2'b00);
    assign above_hi  = (level >= HI_LVL);
    assign below_lo  = (level <= LO_LVL);
    assign host_take = (state_q == E_CLEAR) && host_mode && !mode_chg
                       && (cmd_xon || cmd_xoff);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= E_CLEAR;
            mode_q      <= 2'b00;
            host_stop_q <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode;
            if (host_take) host_stop_q <= cmd_xoff;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            E_CLEAR: begin
                if (auto_rx && above_hi)           state_d = E_REQ_XOFF;
                else if (host_mode && (cmd_xon || cmd_xoff)) state_d = E_HOST_REQ;
            end
            E_REQ_XOFF: begin
                if (ins_ack) state_d = E_HELD;
            end
            E_HELD: begin
                if (below_lo) state_d = E_REQ_XON;
            end
            E_REQ_XON: begin
                if (ins_ack) state_d = E_CLEAR;
            end
            E_HOST_REQ: begin
                if (ins_ack) state_d = E_CLEAR;
            end
            default: state_d = E_CLEAR;
        endcase
        if (mode_chg) state_d = E_CLEAR;
    end

    always_comb begin
        ins_req  = 1'b0;
        ins_char = resume_code;
        unique case (state_q)
            E_REQ_XOFF: begin
                ins_req  = 1'b1;
                ins_char = stop_code;
            end
            E_REQ_XON: begin
                ins_req  = 1'b1;
                ins_char = resume_code;
            end
            E_HOST_REQ: begin
                ins_req  = 1'b1;
                ins_char = host_stop_q ? stop_code : resume_code;
            end
            default: ;
        endcase
    end

    // R4
    hi_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == E_CLEAR && auto_rx && above_hi && !mode_chg)
            |=> (ins_req && ins_char == stop_code));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_req && !ins_ack && !mode_chg) |=> ins_req);

    // R5
    no_double_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_req && ins_ack && state_q == E_REQ_XOFF) |=> !ins_req);

    // R6
    host_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == E_CLEAR && !host_mode && !(auto_rx && above_hi)) |=> !ins_req);

    // R11
    mode_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> !ins_req);
endmodule

// File: rtl/xonxoff_flow_ctrl.sv
`timescale 1ns/1ps
module xonxoff_flow_ctrl
    import xfc_pkg::*;
#(
    parameter int DW      = 8,
    parameter int AW      = 2,
    parameter int LVL_W   = 9,
    parameter int HI_MARK = 240,
    parameter int LO_MARK = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [DW-1:0]    rx_data,
    output logic             rx_wr_en,
    output logic [DW-1:0]    rx_wr_data,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             tx_busy,
    output logic             tx_allow,
    output logic             ins_req,
    output logic [DW-1:0]    ins_char,
    input  logic             ins_ack,
    input  logic             cmd_xon,
    input  logic             cmd_xoff,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             irq
);
    logic [1:0]    mode;
    logic          strip;
    logic [DW-1:0] resume_code;
    logic [DW-1:0] stop_code;
    logic          stop_hit;
    logic          resume_hit;
    logic          tx_halted;

    assign stop_hit   = rx_valid && (rx_data == stop_code);
    assign resume_hit = rx_valid && (rx_data == resume_code) && !stop_hit;

    assign rx_wr_en   = rx_valid && !(strip && (stop_hit || resume_hit));
    assign rx_wr_data = rx_data;

    xfc_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_rd      (reg_rd),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .resume_hit  (resume_hit),
        .stop_hit    (stop_hit),
        .tx_halted   (tx_halted),
        .mode        (mode),
        .strip       (strip),
        .resume_code (resume_code),
        .stop_code   (stop_code),
        .irq         (irq)
    );

    xfc_tx_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_tx    (mode[0]),
        .resume_hit (resume_hit),
        .stop_hit   (stop_hit),
        .tx_busy    (tx_busy),
        .tx_allow   (tx_allow),
        .tx_halted  (tx_halted)
    );

    xfc_rx_emit #(
        .DW      (DW),
        .LVL_W   (LVL_W),
        .HI_MARK (HI_MARK),
        .LO_MARK (LO_MARK)
    ) u_emit (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .level       (fifo_level),
        .cmd_xon     (cmd_xon),
        .cmd_xoff    (cmd_xoff),
        .ins_ack     (ins_ack),
        .resume_code (resume_code),
        .stop_code   (stop_code),
        .ins_req     (ins_req),
        .ins_char    (ins_char)
    );

    // R7
    strip_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !strip) |-> (rx_wr_en && rx_wr_data == rx_data));
endmodule

// File: tb/sim_xonxoff_flow_ctrl.sv
`timescale 1ns/1ps
module sim_xonxoff_flow_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_wr_en;
    logic [7:0] rx_wr_data;
    logic [8:0] fifo_level = '0;
    logic       tx_busy = 1'b0;
    logic       tx_allow;
    logic       ins_req;
    logic [7:0] ins_char;
    logic       ins_ack = 1'b0;
    logic       cmd_xon = 1'b0;
    logic       cmd_xoff = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    xonxoff_flow_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_wr_en(rx_wr_en), .rx_wr_data(rx_wr_data), .fifo_level(fifo_level),
        .tx_busy(tx_busy), .tx_allow(tx_allow), .ins_req(ins_req),
        .ins_char(ins_char), .ins_ack(ins_ack), .cmd_xon(cmd_xon),
        .cmd_xoff(cmd_xoff), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    // {ctrl, char, exp_wr_en, exp_tx_allow, exp_status[2:0]}
    localparam logic [20:0] VEC [8] = '{
        {8'h01, 8'h13, 1'b1, 1'b0, 3'b110},
        {8'h05, 8'h13, 1'b0, 1'b0, 3'b110},
        {8'h00, 8'h13, 1'b1, 1'b1, 3'b110},
        {8'h01, 8'h11, 1'b1, 1'b1, 3'b001},
        {8'h07, 8'h11, 1'b0, 1'b1, 3'b001},
        {8'h02, 8'h13, 1'b1, 1'b1, 3'b110},
        {8'h01, 8'h41, 1'b1, 1'b1, 3'b000},
        {8'h05, 8'h12, 1'b1, 1'b1, 3'b000}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Call at a falling edge; samples, then consumes one clock.
    task automatic rreg(input logic [1:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic send(input logic [7:0] c, output logic we);
        rx_valid = 1'b1; rx_data = c;
        #1 we = rx_wr_en;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ack_once;
        ins_ack = 1'b1;
        @(negedge clk);
        ins_ack = 1'b0;
        #1;
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            finish_run();
        end
    end

    initial begin
        logic [7:0] rd;
        logic we;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 tx_allow", 16'(tx_allow), 16'h1);
        chk("R1 ins_req", 16'(ins_req), 16'h0);
        chk("R1 irq", 16'(irq), 16'h0);
        rreg(2'd0, rd); chk("R1 ctrl", 16'(rd), 16'h00);
        rreg(2'd1, rd); chk("R1 resume code", 16'(rd), 16'h11);
        rreg(2'd2, rd); chk("R1 stop code", 16'(rd), 16'h13);

        // R2 R7 R8 R10 vector table
        foreach (VEC[i]) begin
            wreg(2'd0, 8'h00);
            wreg(2'd0, VEC[i][20:13]);
            rreg(2'd3, rd);
            send(VEC[i][12:5], we);
            chk($sformatf("R7 vec%0d wr_en", i), 16'(we), 16'(VEC[i][4]));
            #1 chk($sformatf("R2 vec%0d tx_allow", i), 16'(tx_allow), 16'(VEC[i][3]));
            rreg(2'd3, rd);
            chk($sformatf("R8 vec%0d status", i), 16'(rd[2:0]), 16'(VEC[i][2:0]));
        end

        // R3 stop while a character is in flight
        wreg(2'd0, 8'h00);
        wreg(2'd0, 8'h01);
        tx_busy = 1'b1;
        send(8'h13, we);
        #1 chk("R3 allow low while busy", 16'(tx_allow), 16'h0);
        rreg(2'd3, rd); chk("R3 not halted while busy", 16'(rd[3]), 16'h0);
        tx_busy = 1'b0;
        idle(1);
        rreg(2'd3, rd); chk("R3 halted after busy falls", 16'(rd[3]), 16'h1);
        send(8'h11, we);
        #1 chk("R2 resume restores allow", 16'(tx_allow), 16'h1);

        // R10 programmable resume code
        wreg(2'd1, 8'h55);
        rreg(2'd1, rd); chk("R10 resume code write", 16'(rd), 16'h55);
        send(8'h13, we);
        #1 chk("R10 stop halts", 16'(tx_allow), 16'h0);
        send(8'h11, we);
        #1 chk("R10 old code no effect", 16'(tx_allow), 16'h0);
        chk("R10 old code is data", 16'(we), 16'h1);
        send(8'h55, we);
        #1 chk("R10 new code resumes", 16'(tx_allow), 16'h1);
        wreg(2'd1, 8'h11);

        // R4 R5 thresholds with hysteresis
        wreg(2'd0, 8'h02);
        idle(2);
        fifo_level = 9'd239;
        idle(1); #1 chk("R4 below mark no request", 16'(ins_req), 16'h0);
        fifo_level = 9'd240;
        idle(1); #1 chk("R4 stop requested", 16'({ins_req, ins_char}), 16'h113);
        idle(3); #1 chk("R4 request held", 16'(ins_req), 16'h1);
        ack_once();
        chk("R4 released on ack", 16'(ins_req), 16'h0);
        fifo_level = 9'd200; idle(2);
        fifo_level = 9'd240; idle(2);
        #1 chk("R5 no second stop", 16'(ins_req), 16'h0);
        fifo_level = 9'd129; idle(2);
        #1 chk("R5 129 no resume", 16'(ins_req), 16'h0);
        fifo_level = 9'd128;
        idle(1); #1 chk("R5 resume requested", 16'({ins_req, ins_char}), 16'h111);
        ack_once();
        chk("R5 resume released", 16'(ins_req), 16'h0);

        // R11 mode change cancels request
        fifo_level = 9'd240;
        idle(1); #1 chk("R11 request before change", 16'(ins_req), 16'h1);
        wreg(2'd0, 8'h00);
        idle(1); #1 chk("R11 request cancelled", 16'(ins_req), 16'h0);
        wreg(2'd0, 8'h02);
        idle(2); #1 chk("R11 flag cleared re-request", 16'({ins_req, ins_char}), 16'h113);
        fifo_level = 9'd0;
        wreg(2'd0, 8'h00);
        idle(2);

        // R6 host commands
        cmd_xoff = 1'b1; @(negedge clk); cmd_xoff = 1'b0;
        #1 chk("R6 host stop", 16'({ins_req, ins_char}), 16'h113);
        ack_once();
        cmd_xon = 1'b1; @(negedge clk); cmd_xon = 1'b0;
        #1 chk("R6 host resume", 16'({ins_req, ins_char}), 16'h111);
        ack_once();
        wreg(2'd0, 8'h01);
        idle(2);
        cmd_xon = 1'b1; @(negedge clk); cmd_xon = 1'b0;
        #1 chk("R6 ignored in auto mode", 16'(ins_req), 16'h0);
        idle(1); #1 chk("R6 still ignored", 16'(ins_req), 16'h0);

        // R8 R9 interrupt masking and read clear
        wreg(2'd0, 8'h10);
        rreg(2'd3, rd);
        send(8'h11, we);
        #1 chk("R8 masked resume no irq", 16'(irq), 16'h0);
        send(8'h13, we);
        #1 chk("R8 stop raises irq", 16'(irq), 16'h1);
        rreg(2'd3, rd);
        chk("R8 status bits", 16'(rd[2:0]), 16'h7);
        #1 chk("R9 irq cleared by read", 16'(irq), 16'h0);

        done = 1;
        finish_run();
    end
endmodule